// File: doc/BRIEF.md
# Configuration Access Filter and Router

This block sits between the configuration request source of a PCIe root port and the two places a configuration access can land: the controller's own register space, and the remote configuration path that carries accesses to devices below the link. Each request names a bus, device and function, a register offset, an access width and (for writes) data. The block decides whether the request is permitted, routes a permitted one, and produces a response with read data, an error flag and a reason code.

Permission depends on four static or slowly moving inputs: whether the controller is strapped as an endpoint, whether it is enabled, the root bus number, and the 7-bit link training state. A refused read returns all ones at the requested width. A refused write disappears without any strobe. Permitted accesses to the root bus go to local registers. Permitted accesses to buses further down produce a target word that the remote path uses to address its configuration cycle. Narrow accesses are steered onto byte lanes by the low offset bits.

The block is a two-stage pipeline. Forwarding strobes appear one cycle after a request is accepted. The response appears one cycle after that, and the selected read data input is sampled while the forwarding strobe is high.

Top module: `cfg_router`

## Requirements
- R1: While `mode_ep_i` is 1 (controller strapped as endpoint), every request of valid width is refused with reason code 1.
- R2: While `ctrl_en_i` is 0, every request of valid width not already refused by R1 is refused with reason code 2.
- R3: A request whose bus number is below `root_bus_i` is refused with reason code 3.
- R4: A request whose bus number is above `root_bus_i` is permitted only while `link_state_i` equals 7'h2D; otherwise it is refused with reason code 4. Root bus requests do not depend on the link state.
- R5: A request to the root bus, or to the bus numbered `root_bus_i`+1, with a nonzero device number is refused with reason code 5. A nonzero device number is permitted on buses two or more below the root.
- R6: A refused read returns 0xFF, 0xFFFF or 0xFFFFFFFF for widths 8, 16 and 32, zero-extended to 32 bits. A refused request raises neither `loc_valid_o` nor `rmt_valid_o`, and a refused write responds with data 0.
- R7: A permitted root bus request raises `loc_valid_o`. Any other permitted request raises `rmt_valid_o` with `rmt_target_o` holding the bus minus the root bus in bits 31:24, the device in bits 23:19, the function in bits 18:16 and zeros elsewhere. The forwarded address is the offset with bits 1:0 cleared.
- R8: `req_size_i` encodes 0 = 8-bit, 1 = 16-bit, 2 = 32-bit. Encoding 3 is checked before any other rule: it sets `resp_err_o`, reason code 6 and data 0, and forwards nothing.
- R9: Refusal rules are evaluated in the order R8, R1, R2, R3, R4, R5, and the first failing rule sets the reason code. A permitted request has reason code 0 and `resp_err_o` low.
- R10: An 8-bit access uses byte lane offset[1:0]. A 16-bit access uses lanes {offset[1],0} and {offset[1],1}, and a 32-bit access uses all four. The byte enables mark those lanes, write data is shifted from the low bits onto them, and read data is taken from them and zero-extended.
- R11: The forwarding strobe is high exactly one cycle after a request is accepted (`req_valid_i` high at a clock edge). `resp_valid_o` is high exactly two cycles after it, and all strobes are low out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_ep_i | input | 1 | Controller strapped as endpoint |
| ctrl_en_i | input | 1 | Controller enabled |
| root_bus_i | input | 8 | Root bus number |
| link_state_i | input | 7 | Link training state |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bus_i | input | 8 | Requested bus |
| req_dev_i | input | 5 | Requested device |
| req_func_i | input | 3 | Requested function |
| req_off_i | input | 12 | Register byte offset |
| req_size_i | input | 2 | Access width code |
| req_wdata_i | input | 32 | Write data, low-aligned |
| loc_valid_o | output | 1 | Local register access strobe |
| loc_write_o | output | 1 | Local access is a write |
| loc_addr_o | output | 12 | Local word-aligned address |
| loc_be_o | output | 4 | Local byte enables |
| loc_wdata_o | output | 32 | Local lane-aligned write data |
| loc_rdata_i | input | 32 | Local read data during the strobe |
| rmt_valid_o | output | 1 | Remote configuration access strobe |
| rmt_write_o | output | 1 | Remote access is a write |
| rmt_target_o | output | 32 | Remote target word |
| rmt_addr_o | output | 12 | Remote word-aligned address |
| rmt_be_o | output | 4 | Remote byte enables |
| rmt_wdata_o | output | 32 | Remote lane-aligned write data |
| rmt_rdata_i | input | 32 | Remote read data during the strobe |
| resp_valid_o | output | 1 | Response present |
| resp_err_o | output | 1 | Invalid access width |
| resp_reason_o | output | 3 | Reason code, 0 when permitted |
| resp_rdata_o | output | 32 | Response read data |

## Verification
The bench builds the block with its default widths: an 8-bit bus, a 5-bit device, a 3-bit function, a 12-bit offset, a 7-bit link state and an L0 code of 7'h2D. The root bus is held at 4, so buses 3, 4, 5 and 6 give the below-root, root, root-plus-one and deeper cases, with the device rule checked on each side of its boundary. Link state, enable and endpoint strap are toggled between requests, and some requests break several rules at once so that the order of the rules can be seen in the reason code. The local and remote read data inputs carry distinct fixed patterns, so every lane and width choice gives a unique expected value.

// File: rtl/cfg_rt_pkg.sv
package cfg_rt_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BE_W   = DATA_W / 8;

  typedef enum logic [1:0] {
    SZ_B   = 2'd0,
    SZ_H   = 2'd1,
    SZ_W   = 2'd2,
    SZ_BAD = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    RSN_OK    = 3'd0,
    RSN_EP    = 3'd1,
    RSN_OFF   = 3'd2,
    RSN_BELOW = 3'd3,
    RSN_LINK  = 3'd4,
    RSN_DEV   = 3'd5,
    RSN_SIZE  = 3'd6
  } reason_e;

  typedef enum logic [1:0] {
    RT_NONE   = 2'd0,
    RT_LOCAL  = 2'd1,
    RT_REMOTE = 2'd2
  } route_e;
endpackage

// File: rtl/cfg_req_filter.sv
module cfg_req_filter
  import cfg_rt_pkg::*;
#(
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned DEV_W  = 5,
  parameter int unsigned LINK_W = 7,
  parameter logic [LINK_W-1:0] L0_CODE = 7'h2D
) (
  input  acc_size_e          size_i,
  input  logic               mode_ep_i,
  input  logic               ctrl_en_i,
  input  logic [BUS_W-1:0]   root_bus_i,
  input  logic [LINK_W-1:0]  link_state_i,
  input  logic [BUS_W-1:0]   bus_i,
  input  logic [DEV_W-1:0]   dev_i,
  output reason_e            reason_o,
  output route_e             route_o,
  output logic               err_o
);
  logic [BUS_W:0] root_nx;
  logic           on_root, below_root, above_root, near_root, link_up;

  assign root_nx    = {1'b0, root_bus_i} + {{BUS_W{1'b0}}, 1'b1};
  assign on_root    = (bus_i == root_bus_i);
  assign below_root = (bus_i < root_bus_i);
  assign above_root = (bus_i > root_bus_i);
  assign near_root  = on_root || ({1'b0, bus_i} == root_nx);
  assign link_up    = (link_state_i == L0_CODE);

  // first failing rule wins
  always_comb begin
    if (size_i == SZ_BAD)               reason_o = RSN_SIZE;
    else if (mode_ep_i)                 reason_o = RSN_EP;
    else if (!ctrl_en_i)                reason_o = RSN_OFF;
    else if (below_root)                reason_o = RSN_BELOW;
    else if (above_root && !link_up)    reason_o = RSN_LINK;
    else if (near_root && (dev_i != '0)) reason_o = RSN_DEV;
    else                                reason_o = RSN_OK;
  end

  always_comb begin
    if (reason_o != RSN_OK) route_o = RT_NONE;
    else if (on_root)       route_o = RT_LOCAL;
    else                    route_o = RT_REMOTE;
  end

  assign err_o = (size_i == SZ_BAD);
endmodule

// File: rtl/cfg_target_build.sv
module cfg_target_build
  import cfg_rt_pkg::*;
#(
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned DEV_W  = 5,
  parameter int unsigned FUNC_W = 3
) (
  input  logic [BUS_W-1:0]  root_bus_i,
  input  logic [BUS_W-1:0]  bus_i,
  input  logic [DEV_W-1:0]  dev_i,
  input  logic [FUNC_W-1:0] func_i,
  output logic [DATA_W-1:0] target_o
);
  localparam int unsigned BUS_MSB  = DATA_W - 1;
  localparam int unsigned DEV_MSB  = BUS_MSB - BUS_W;
  localparam int unsigned FUNC_MSB = DEV_MSB - DEV_W;

  logic [BUS_W-1:0] rel_bus;
  assign rel_bus = bus_i - root_bus_i;

  always_comb begin
    target_o                      = '0;
    target_o[BUS_MSB  -: BUS_W]   = rel_bus;
    target_o[DEV_MSB  -: DEV_W]   = dev_i;
    target_o[FUNC_MSB -: FUNC_W]  = func_i;
  end
endmodule

// File: rtl/cfg_lane_wr.sv
module cfg_lane_wr
  import cfg_rt_pkg::*;
(
  input  acc_size_e         size_i,
  input  logic [1:0]        lane_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [BE_W-1:0]   be_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic [1:0] base;
  logic [4:0] shamt;

  always_comb begin
    unique case (size_i)
      SZ_B:    begin base = lane_i;             be_o = 4'b0001 << lane_i; end
      SZ_H:    begin base = {lane_i[1], 1'b0};  be_o = lane_i[1] ? 4'b1100 : 4'b0011; end
      SZ_W:    begin base = 2'd0;               be_o = 4'b1111; end
      default: begin base = 2'd0;               be_o = 4'b0000; end
    endcase
  end

  assign shamt   = {base, 3'b000};
  assign wdata_o = wdata_i << shamt;
endmodule

// File: rtl/cfg_lane_rd.sv
module cfg_lane_rd
  import cfg_rt_pkg::*;
(
  input  acc_size_e         size_i,
  input  logic [1:0]        lane_i,
  input  logic [DATA_W-1:0] raw_i,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] fill_o
);
  logic [1:0]        base;
  logic [DATA_W-1:0] shifted;

  always_comb begin
    unique case (size_i)
      SZ_B:    base = lane_i;
      SZ_H:    base = {lane_i[1], 1'b0};
      default: base = 2'd0;
    endcase
  end

  assign shifted = raw_i >> {base, 3'b000};

  always_comb begin
    unique case (size_i)
      SZ_B:    begin data_o = {24'd0, shifted[7:0]};  fill_o = 32'h0000_00FF; end
      SZ_H:    begin data_o = {16'd0, shifted[15:0]}; fill_o = 32'h0000_FFFF; end
      SZ_W:    begin data_o = shifted;                fill_o = 32'hFFFF_FFFF; end
      default: begin data_o = '0;                     fill_o = '0;            end
    endcase
  end
endmodule

// File: rtl/cfg_router.sv
module cfg_router
  import cfg_rt_pkg::*;
#(
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned DEV_W  = 5,
  parameter int unsigned FUNC_W = 3,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned LINK_W = 7,
  parameter logic [LINK_W-1:0] L0_CODE = 7'h2D
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mode_ep_i,
  input  logic               ctrl_en_i,
  input  logic [BUS_W-1:0]   root_bus_i,
  input  logic [LINK_W-1:0]  link_state_i,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [BUS_W-1:0]   req_bus_i,
  input  logic [DEV_W-1:0]   req_dev_i,
  input  logic [FUNC_W-1:0]  req_func_i,
  input  logic [OFF_W-1:0]   req_off_i,
  input  logic [1:0]         req_size_i,
  input  logic [DATA_W-1:0]  req_wdata_i,
  output logic               loc_valid_o,
  output logic               loc_write_o,
  output logic [OFF_W-1:0]   loc_addr_o,
  output logic [BE_W-1:0]    loc_be_o,
  output logic [DATA_W-1:0]  loc_wdata_o,
  input  logic [DATA_W-1:0]  loc_rdata_i,
  output logic               rmt_valid_o,
  output logic               rmt_write_o,
  output logic [DATA_W-1:0]  rmt_target_o,
  output logic [OFF_W-1:0]   rmt_addr_o,
  output logic [BE_W-1:0]    rmt_be_o,
  output logic [DATA_W-1:0]  rmt_wdata_o,
  input  logic [DATA_W-1:0]  rmt_rdata_i,
  output logic               resp_valid_o,
  output logic               resp_err_o,
  output logic [2:0]         resp_reason_o,
  output logic [DATA_W-1:0]  resp_rdata_o
);
  acc_size_e         req_size;
  reason_e           d_reason;
  route_e            d_route;
  logic              d_err;
  logic [DATA_W-1:0] d_target, d_wdata;
  logic [BE_W-1:0]   d_be;

  assign req_size = acc_size_e'(req_size_i);

  cfg_req_filter #(
    .BUS_W(BUS_W), .DEV_W(DEV_W), .LINK_W(LINK_W), .L0_CODE(L0_CODE)
  ) u_filter (
    .size_i       (req_size),
    .mode_ep_i    (mode_ep_i),
    .ctrl_en_i    (ctrl_en_i),
    .root_bus_i   (root_bus_i),
    .link_state_i (link_state_i),
    .bus_i        (req_bus_i),
    .dev_i        (req_dev_i),
    .reason_o     (d_reason),
    .route_o      (d_route),
    .err_o        (d_err)
  );

  cfg_target_build #(
    .BUS_W(BUS_W), .DEV_W(DEV_W), .FUNC_W(FUNC_W)
  ) u_target (
    .root_bus_i (root_bus_i),
    .bus_i      (req_bus_i),
    .dev_i      (req_dev_i),
    .func_i     (req_func_i),
    .target_o   (d_target)
  );

  cfg_lane_wr u_lane_wr (
    .size_i  (req_size),
    .lane_i  (req_off_i[1:0]),
    .wdata_i (req_wdata_i),
    .be_o    (d_be),
    .wdata_o (d_wdata)
  );

  // stage 1: decision and forwarding
  logic              s1_valid, s1_write, s1_err;
  route_e            s1_route;
  reason_e           s1_reason;
  acc_size_e         s1_size;
  logic [1:0]        s1_lane;
  logic [OFF_W-1:0]  s1_addr;
  logic [BE_W-1:0]   s1_be;
  logic [DATA_W-1:0] s1_wdata, s1_target;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid  <= 1'b0;
      s1_write  <= 1'b0;
      s1_err    <= 1'b0;
      s1_route  <= RT_NONE;
      s1_reason <= RSN_OK;
      s1_size   <= SZ_W;
      s1_lane   <= '0;
      s1_addr   <= '0;
      s1_be     <= '0;
      s1_wdata  <= '0;
      s1_target <= '0;
    end else begin
      s1_valid <= req_valid_i;
      if (req_valid_i) begin
        s1_write  <= req_write_i;
        s1_err    <= d_err;
        s1_route  <= d_route;
        s1_reason <= d_reason;
        s1_size   <= req_size;
        s1_lane   <= req_off_i[1:0];
        s1_addr   <= {req_off_i[OFF_W-1:2], 2'b00};
        s1_be     <= d_be;
        s1_wdata  <= d_wdata;
        s1_target <= (d_route == RT_REMOTE) ? d_target : '0;
      end
    end
  end

  assign loc_valid_o  = s1_valid && (s1_route == RT_LOCAL);
  assign loc_write_o  = s1_write;
  assign loc_addr_o   = s1_addr;
  assign loc_be_o     = s1_be;
  assign loc_wdata_o  = s1_wdata;
  assign rmt_valid_o  = s1_valid && (s1_route == RT_REMOTE);
  assign rmt_write_o  = s1_write;
  assign rmt_target_o = s1_target;
  assign rmt_addr_o   = s1_addr;
  assign rmt_be_o     = s1_be;
  assign rmt_wdata_o  = s1_wdata;

  // stage 2: response
  logic [DATA_W-1:0] rd_raw, rd_ext, rd_fill, rsp_data;

  assign rd_raw = (s1_route == RT_REMOTE) ? rmt_rdata_i : loc_rdata_i;

  cfg_lane_rd u_lane_rd (
    .size_i (s1_size),
    .lane_i (s1_lane),
    .raw_i  (rd_raw),
    .data_o (rd_ext),
    .fill_o (rd_fill)
  );

  always_comb begin
    if (s1_err || s1_write)        rsp_data = '0;
    else if (s1_route == RT_NONE)  rsp_data = rd_fill;
    else                           rsp_data = rd_ext;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o  <= 1'b0;
      resp_err_o    <= 1'b0;
      resp_reason_o <= '0;
      resp_rdata_o  <= '0;
    end else begin
      resp_valid_o <= s1_valid;
      if (s1_valid) begin
        resp_err_o    <= s1_err;
        resp_reason_o <= s1_reason;
        resp_rdata_o  <= rsp_data;
      end
    end
  end
endmodule

// File: rtl/cfg_router_chk.sv
module cfg_router_chk #(
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned LINK_W = 7,
  parameter logic [LINK_W-1:0] L0_CODE = 7'h2D
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_ep_i,
  input logic              ctrl_en_i,
  input logic [BUS_W-1:0]  root_bus_i,
  input logic [LINK_W-1:0] link_state_i,
  input logic              req_valid_i,
  input logic [BUS_W-1:0]  req_bus_i,
  input logic              loc_valid_o,
  input logic              rmt_valid_o,
  input logic              resp_valid_o,
  input logic              resp_err_o,
  input logic [2:0]        resp_reason_o,
  input logic [31:0]       resp_rdata_o
);
  // R1 R2
  strap_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_valid_o || rmt_valid_o) |-> $past(!mode_ep_i && ctrl_en_i));

  // R3
  local_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_valid_o |-> $past(req_bus_i == root_bus_i));

  // R4
  remote_link_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rmt_valid_o |-> $past((link_state_i == L0_CODE) && (req_bus_i > root_bus_i)));

  // R6
  refused_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_reason_o != 3'd0) |-> $past(!loc_valid_o && !rmt_valid_o));

  // R6
  refused_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_reason_o >= 3'd1 && resp_reason_o <= 3'd5 && resp_rdata_o != 32'd0)
      |-> (resp_rdata_o == 32'hFF || resp_rdata_o == 32'hFFFF || resp_rdata_o == 32'hFFFF_FFFF));

  // R8
  bad_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_err_o) |-> (resp_rdata_o == 32'd0 && resp_reason_o == 3'd6));

  // R9
  reason_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> (resp_reason_o <= 3'd6 && (resp_err_o == (resp_reason_o == 3'd6))));

  // R11
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> $past(req_valid_i, 2));

  // R11
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({loc_valid_o, rmt_valid_o}));
endmodule

bind cfg_router cfg_router_chk #(
  .BUS_W(BUS_W), .LINK_W(LINK_W), .L0_CODE(L0_CODE)
) u_chk (.*);

// File: tb/cfg_router_bench.sv
`timescale 1ns/1ps
module cfg_router_bench;
  localparam logic [31:0] LOC_PAT = 32'hA1B2_C3D4;
  localparam logic [31:0] RMT_PAT = 32'h1122_3344;
  localparam logic [7:0]  ROOT    = 8'd4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        mode_ep, ctrl_en, req_valid, req_write;
  logic [7:0]  root_bus, req_bus;
  logic [6:0]  link_state;
  logic [4:0]  req_dev;
  logic [2:0]  req_func;
  logic [11:0] req_off;
  logic [1:0]  req_size;
  logic [31:0] req_wdata;
  logic        loc_valid_o, loc_write_o, rmt_valid_o, rmt_write_o;
  logic [11:0] loc_addr_o, rmt_addr_o;
  logic [3:0]  loc_be_o, rmt_be_o;
  logic [31:0] loc_wdata_o, rmt_wdata_o, rmt_target_o, resp_rdata_o;
  logic        resp_valid_o, resp_err_o;
  logic [2:0]  resp_reason_o;

  cfg_router u_cfg_router (
    .clk_i(clk), .rst_ni(rst_n), .mode_ep_i(mode_ep), .ctrl_en_i(ctrl_en),
    .root_bus_i(root_bus), .link_state_i(link_state),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_bus_i(req_bus),
    .req_dev_i(req_dev), .req_func_i(req_func), .req_off_i(req_off),
    .req_size_i(req_size), .req_wdata_i(req_wdata),
    .loc_valid_o(loc_valid_o), .loc_write_o(loc_write_o), .loc_addr_o(loc_addr_o),
    .loc_be_o(loc_be_o), .loc_wdata_o(loc_wdata_o), .loc_rdata_i(LOC_PAT),
    .rmt_valid_o(rmt_valid_o), .rmt_write_o(rmt_write_o), .rmt_target_o(rmt_target_o),
    .rmt_addr_o(rmt_addr_o), .rmt_be_o(rmt_be_o), .rmt_wdata_o(rmt_wdata_o),
    .rmt_rdata_i(RMT_PAT),
    .resp_valid_o(resp_valid_o), .resp_err_o(resp_err_o),
    .resp_reason_o(resp_reason_o), .resp_rdata_o(resp_rdata_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] rdata;
    logic        err;
    logic [2:0]  reason;
    string       tag;
  } exp_t;
  exp_t sb[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] lane_base(input logic [1:0] sz, input logic [11:0] off);
    if (sz == 2'd0) return off[1:0];
    if (sz == 2'd1) return {off[1], 1'b0};
    return 2'd0;
  endfunction

  function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [11:0] off);
    if (sz == 2'd0) return 4'b0001 << off[1:0];
    if (sz == 2'd1) return 4'b0011 << {off[1], 1'b0};
    return 4'b1111;
  endfunction

  function automatic logic [31:0] width_mask(input logic [1:0] sz);
    if (sz == 2'd0) return 32'hFF;
    if (sz == 2'd1) return 32'hFFFF;
    return 32'hFFFF_FFFF;
  endfunction

  // monitor: pops expected responses in order
  always @(negedge clk) begin
    if (rst_n && resp_valid_o) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R11 unexpected response", {31'd0, resp_valid_o}, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(resp_rdata_o == e.rdata, {e.tag, " rdata"}, resp_rdata_o, e.rdata);
        chk(resp_err_o == e.err, {e.tag, " err"}, {31'd0, resp_err_o}, {31'd0, e.err});
        chk(resp_reason_o == e.reason, {e.tag, " reason"}, {29'd0, resp_reason_o}, {29'd0, e.reason});
      end
    end
  end

  // driver: drives at a falling edge, checks strobes one cycle later and response two cycles later
  task automatic issue(input bit wr, input logic [7:0] bus, input logic [4:0] dev,
                       input logic [2:0] fn, input logic [11:0] off, input logic [1:0] sz,
                       input logic [31:0] wd, input logic [2:0] rsn, input string tag);
    exp_t e;
    logic        to_loc;
    logic [31:0] tgt, raw, ewd;
    logic [3:0]  ebe;
    to_loc = (bus == root_bus);
    raw    = to_loc ? LOC_PAT : RMT_PAT;
    ebe    = exp_be(sz, off);
    ewd    = (wd & width_mask(sz)) << {lane_base(sz, off), 3'b000};
    tgt    = {bus - root_bus, dev, fn, 16'd0};
    e.tag    = tag;
    e.reason = rsn;
    e.err    = (sz == 2'd3);
    if (sz == 2'd3 || wr)  e.rdata = 32'd0;
    else if (rsn != 3'd0)  e.rdata = width_mask(sz);
    else                   e.rdata = (raw >> {lane_base(sz, off), 3'b000}) & width_mask(sz);
    req_valid = 1'b1; req_write = wr; req_bus = bus; req_dev = dev; req_func = fn;
    req_off = off; req_size = sz; req_wdata = wd;
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
    if (rsn != 3'd0) begin
      chk(!loc_valid_o && !rmt_valid_o, {tag, " R6 no strobe"}, {30'd0, loc_valid_o, rmt_valid_o}, 32'd0);
    end else if (to_loc) begin
      chk(loc_valid_o && !rmt_valid_o, {tag, " R7 local strobe"}, {30'd0, loc_valid_o, rmt_valid_o}, 32'd2);
      chk(loc_addr_o == {off[11:2], 2'b00}, {tag, " R7 local addr"}, {20'd0, loc_addr_o}, {20'd0, off[11:2], 2'b00});
      chk(loc_be_o == ebe, {tag, " R10 local be"}, {28'd0, loc_be_o}, {28'd0, ebe});
      chk(loc_write_o == wr, {tag, " R7 local dir"}, {31'd0, loc_write_o}, {31'd0, wr});
      if (wr) chk(loc_wdata_o == ewd, {tag, " R10 local wdata"}, loc_wdata_o, ewd);
    end else begin
      chk(rmt_valid_o && !loc_valid_o, {tag, " R7 remote strobe"}, {30'd0, loc_valid_o, rmt_valid_o}, 32'd1);
      chk(rmt_target_o == tgt, {tag, " R7 target"}, rmt_target_o, tgt);
      chk(rmt_addr_o == {off[11:2], 2'b00}, {tag, " R7 remote addr"}, {20'd0, rmt_addr_o}, {20'd0, off[11:2], 2'b00});
      chk(rmt_be_o == ebe, {tag, " R10 remote be"}, {28'd0, rmt_be_o}, {28'd0, ebe});
      if (wr) chk(rmt_wdata_o == ewd, {tag, " R10 remote wdata"}, rmt_wdata_o, ewd);
    end
    @(negedge clk);
    chk(resp_valid_o == 1'b1, {tag, " R11 response latency"}, {31'd0, resp_valid_o}, 32'd1);
  endtask

  initial begin
    mode_ep = 1'b0; ctrl_en = 1'b1; root_bus = ROOT; link_state = 7'h2D;
    req_valid = 1'b0; req_write = 1'b0; req_bus = '0; req_dev = '0; req_func = '0;
    req_off = '0; req_size = 2'd2; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(!loc_valid_o && !rmt_valid_o && !resp_valid_o, "R11 reset strobes",
        {29'd0, loc_valid_o, rmt_valid_o, resp_valid_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 local reads, R10 lane selection
    issue(0, 8'd4, 5'd0, 3'd0, 12'h010, 2'd2, 32'd0, 3'd0, "R7 local rd32");
    issue(0, 8'd4, 5'd0, 3'd0, 12'h013, 2'd0, 32'd0, 3'd0, "R10 rd8 lane3");
    issue(0, 8'd4, 5'd0, 3'd0, 12'h011, 2'd0, 32'd0, 3'd0, "R10 rd8 lane1");
    issue(0, 8'd4, 5'd0, 3'd0, 12'h012, 2'd1, 32'd0, 3'd0, "R10 rd16 upper");
    issue(0, 8'd4, 5'd0, 3'd0, 12'h014, 2'd1, 32'd0, 3'd0, "R10 rd16 lower");
    issue(1, 8'd4, 5'd0, 3'd0, 12'h021, 2'd0, 32'h0000_005A, 3'd0, "R10 wr8 lane1");
    issue(1, 8'd4, 5'd0, 3'd0, 12'h022, 2'd1, 32'h0000_1234, 3'd0, "R10 wr16 upper");
    // R7 remote, R5 boundary
    issue(0, 8'd5, 5'd0, 3'd3, 12'h100, 2'd2, 32'd0, 3'd0, "R7 remote rd32");
    issue(0, 8'd6, 5'd7, 3'd2, 12'h102, 2'd1, 32'd0, 3'd0, "R5 deep dev7 allowed");
    issue(1, 8'd9, 5'd31, 3'd7, 12'hFFC, 2'd2, 32'hDEAD_BEEF, 3'd0, "R7 remote wr32");
    issue(0, 8'd4, 5'd1, 3'd0, 12'h000, 2'd2, 32'd0, 3'd5, "R5 root dev1");
    issue(0, 8'd5, 5'd3, 3'd0, 12'h003, 2'd0, 32'd0, 3'd5, "R5 root+1 dev3");
    issue(1, 8'd5, 5'd3, 3'd0, 12'h000, 2'd2, 32'h55, 3'd5, "R6 refused write");
    // R3
    issue(0, 8'd3, 5'd0, 3'd0, 12'h002, 2'd1, 32'd0, 3'd3, "R3 below root");
    // R4
    link_state = 7'h11;
    issue(0, 8'd5, 5'd0, 3'd0, 12'h000, 2'd2, 32'd0, 3'd4, "R4 link down");
    issue(0, 8'd4, 5'd0, 3'd0, 12'h010, 2'd2, 32'd0, 3'd0, "R4 root ok link down");
    issue(0, 8'd5, 5'd1, 3'd0, 12'h000, 2'd0, 32'd0, 3'd4, "R9 link before dev");
    link_state = 7'h2C;
    issue(0, 8'd6, 5'd0, 3'd0, 12'h000, 2'd2, 32'd0, 3'd4, "R4 near L0 code");
    link_state = 7'h2D;
    // R2
    ctrl_en = 1'b0;
    issue(0, 8'd4, 5'd0, 3'd0, 12'h000, 2'd2, 32'd0, 3'd2, "R2 disabled rd");
    issue(1, 8'd5, 5'd0, 3'd0, 12'h000, 2'd2, 32'h77, 3'd2, "R2 disabled wr");
    issue(0, 8'd2, 5'd9, 3'd0, 12'h000, 2'd0, 32'd0, 3'd2, "R9 disabled before below");
    // R1
    mode_ep = 1'b1;
    issue(0, 8'd2, 5'd0, 3'd0, 12'h000, 2'd1, 32'd0, 3'd1, "R9 endpoint first");
    ctrl_en = 1'b1;
    issue(0, 8'd4, 5'd0, 3'd0, 12'h000, 2'd2, 32'd0, 3'd1, "R1 endpoint rd");
    // R8
    issue(0, 8'd4, 5'd0, 3'd0, 12'h000, 2'd3, 32'd0, 3'd6, "R8 bad size endpoint");
    mode_ep = 1'b0;
    issue(0, 8'd4, 5'd0, 3'd0, 12'h000, 2'd3, 32'd0, 3'd6, "R8 bad size local");
    issue(1, 8'd5, 5'd0, 3'd0, 12'h000, 2'd3, 32'h1, 3'd6, "R8 bad size remote wr");

    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R11 all responses seen", sb.size(), 32'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R11 actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule